// File: doc/BRIEF.md
# Manual serial bus command engine

This block drives a serial slave link one bus primitive at a time while the normal transaction path is set aside, for instance to put the slave's serial interface back into a known state. Each command word names a single action: set chip select high or low, give one clock pulse, or move a data byte across the link on one, two or four data lanes. A sequencer runs the action on its own chip-select, clock and data registers, and reports busy while it works and done when it finishes.

Two inputs decide who owns the pins. The route select picks either this engine or the normal path. The manual enable lets the engine drive the pins while it is selected. A one-entry holding register accepts a command that arrives while the engine is busy. Sticky flags record commands that were rejected or not understood. For shift commands without the write bit, a small shift-in register collects the data-in lanes.

Top module: `man_bus_engine`

## Requirements
- R1: After reset, bus_cs_n is 1, bus_sck is 0, bus_dout is 0, busy and done are 0, link_idle is 1 and both sticky flags are 0.
- R2: Opcode (cmd_word[11:8]) 0x1 drives chip select low and opcode 0x0 drives it high. Each holds busy for SCK_HALF cycles and produces no clock pulse.
- R3: Opcode 0x2 produces exactly one clock pulse, low for SCK_HALF cycles and then high for SCK_HALF cycles. It leaves chip select and the data lanes unchanged.
- R4: Opcodes 0x8, 0x9 and 0xA with cmd_word[13]=1 send cmd_word[7:0] most significant first in 8, 4 or 2 clock pulses. Each pulse carries 1, 2 or 4 bits on bus_dout[0], bus_dout[1:0] or bus_dout[3:0], with the higher lane holding the earlier bit. Unused lanes are 0, data changes only while the clock is low, and the lanes return to 0 when the command ends.
- R5: The same shift opcodes with cmd_word[13]=0 hold bus_dout at 0. On each rising clock they shift bus_din (lane 0, lanes 1:0 or lanes 3:0) into rd_data from the low end, so the earliest symbol ends in the top bits.
- R6: busy rises at the edge that accepts a command and stays high for 2*SCK_HALF cycles per clock pulse. done is high for one cycle, in the cycle where busy has just fallen.
- R7: A command that arrives while busy is held in one holding entry and runs after the current one ends. A command that arrives while that entry is full is dropped and sets cmd_overrun, which stays set. link_idle is 1 only when the engine is not busy and the entry is empty.
- R8: An opcode outside {0x0,0x1,0x2,0x8,0x9,0xA}, or any command with cmd_word[12]=1, causes no bus activity and no busy cycle, and sets ill_op, which stays set.
- R9: cmd_valid is ignored unless man_en=1 and mux_sel=1.
- R10: With mux_sel=0 the bus outputs follow path_cs_n, path_sck and path_dout. With mux_sel=1 and man_en=0 they sit at cs high, clock low and data 0.
- R11: The slave-reset sequence completes and leaves link_idle=1 and bus_cs_n=1. The sequence is chip select low, one single-lane write, chip select high, then four single-lane writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| man_en | input | 1 | Lets the engine drive the pins when routed |
| mux_sel | input | 1 | 1 routes the pins to the engine, 0 to the normal path |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_word | input | 14 | [13] write, [12] reserved zero, [11:8] opcode, [7:0] data |
| path_cs_n | input | 1 | Chip select from the normal path |
| path_sck | input | 1 | Clock from the normal path |
| path_dout | input | 4 | Data lanes from the normal path |
| bus_din | input | 4 | Data-in lanes from the slave |
| bus_cs_n | output | 1 | Chip select pin, active low |
| bus_sck | output | 1 | Serial clock pin |
| bus_dout | output | 4 | Data-out lanes |
| rd_data | output | 8 | Shift-in register |
| busy | output | 1 | A primitive is running |
| done | output | 1 | One-cycle pulse when a primitive ends |
| link_idle | output | 1 | Not busy and nothing held |
| ill_op | output | 1 | Sticky: an illegal command was seen |
| cmd_overrun | output | 1 | Sticky: a command was dropped |

## Verification
The properties assume that man_en and mux_sel stay constant while a primitive runs and the holding entry is occupied. They also assume cmd_valid is a single-cycle strobe. The stimulus changes the routing inputs only after link_idle has returned to 1, and it drives every input half a cycle away from the active edge. The stimulus changes bus_din only after a rising serial clock has been observed, so each lane value is stable long before the next sampling edge.

// File: rtl/man_bus_pkg.sv
package man_bus_pkg;

  localparam int unsigned CMD_W  = 14;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANE_W = 4;
  localparam int unsigned PULSE_W = $clog2(BYTE_W);

  localparam logic [3:0] OPC_CS_HI = 4'h0;
  localparam logic [3:0] OPC_CS_LO = 4'h1;
  localparam logic [3:0] OPC_CLK   = 4'h2;
  localparam logic [3:0] OPC_SH1   = 4'h8;
  localparam logic [3:0] OPC_SH2   = 4'h9;
  localparam logic [3:0] OPC_SH4   = 4'hA;

  typedef enum logic [1:0] {K_CSHI, K_CSLO, K_CLK, K_SHIFT} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_CSW, S_LOW, S_HIGH} seq_st_e;

  typedef struct packed {
    logic               legal;
    kind_e              kind;
    logic [1:0]         lane_log;   // 0: one lane, 1: two, 2: four
    logic [PULSE_W-1:0] last_pulse; // pulses minus one
    logic               wr;
    logic [BYTE_W-1:0]  data;
  } prim_t;

  // symbol presented on the lanes for the current top of the shift register
  function automatic logic [LANE_W-1:0] lane_sym(logic [BYTE_W-1:0] tx, logic [1:0] ll);
    case (ll)
      2'd0:    lane_sym = {3'b000, tx[7]};
      2'd1:    lane_sym = {2'b00, tx[7:6]};
      default: lane_sym = tx[7:4];
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] tx_advance(logic [BYTE_W-1:0] tx, logic [1:0] ll);
    case (ll)
      2'd0:    tx_advance = {tx[6:0], 1'b0};
      2'd1:    tx_advance = {tx[5:0], 2'b00};
      default: tx_advance = {tx[3:0], 4'h0};
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] rx_advance(logic [BYTE_W-1:0] rx, logic [LANE_W-1:0] din,
                                                   logic [1:0] ll);
    case (ll)
      2'd0:    rx_advance = {rx[6:0], din[0]};
      2'd1:    rx_advance = {rx[5:0], din[1:0]};
      default: rx_advance = {rx[3:0], din[3:0]};
    endcase
  endfunction

endpackage

// File: rtl/man_cmd_decode.sv
module man_cmd_decode
  import man_bus_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  output prim_t            prim
);

  logic [3:0] opc;

  assign opc = word[11:8];

  always_comb begin
    prim            = '0;
    prim.wr         = word[13];
    prim.data       = word[7:0];
    prim.legal      = !word[12];
    prim.kind       = K_CLK;
    prim.lane_log   = 2'd0;
    prim.last_pulse = '0;
    case (opc)
      OPC_CS_HI: prim.kind = K_CSHI;
      OPC_CS_LO: prim.kind = K_CSLO;
      OPC_CLK:   prim.kind = K_CLK;
      OPC_SH1: begin
        prim.kind       = K_SHIFT;
        prim.lane_log   = 2'd0;
        prim.last_pulse = PULSE_W'(BYTE_W - 1);
      end
      OPC_SH2: begin
        prim.kind       = K_SHIFT;
        prim.lane_log   = 2'd1;
        prim.last_pulse = PULSE_W'(BYTE_W / 2 - 1);
      end
      OPC_SH4: begin
        prim.kind       = K_SHIFT;
        prim.lane_log   = 2'd2;
        prim.last_pulse = PULSE_W'(BYTE_W / 4 - 1);
      end
      default: prim.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/man_cmd_hold.sv
module man_cmd_hold
  import man_bus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_in,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             ready,
  output logic             issue,
  output logic [CMD_W-1:0] issue_word,
  output logic             hold_full,
  output logic             overrun
);

  logic             hv_q, hv_d;
  logic [CMD_W-1:0] hw_q, hw_d;
  logic             ovf_q, ovf_d;
  logic             hw_en;

  assign issue      = ready && (hv_q || cmd_in);
  assign issue_word = hv_q ? hw_q : cmd_word;
  assign hold_full  = hv_q;
  assign overrun    = ovf_q;

  always_comb begin
    hv_d  = hv_q;
    hw_d  = hw_q;
    hw_en = 1'b0;
    ovf_d = ovf_q;
    if (ready && hv_q) begin
      // entry drains this edge; a new command takes its place
      hv_d = cmd_in;
      if (cmd_in) begin
        hw_d  = cmd_word;
        hw_en = 1'b1;
      end
    end else if (!ready && cmd_in) begin
      if (!hv_q) begin
        hv_d  = 1'b1;
        hw_d  = cmd_word;
        hw_en = 1'b1;
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q  <= 1'b0;
      hw_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      hv_q  <= hv_d;
      ovf_q <= ovf_d;
      if (hw_en) hw_q <= hw_d;
    end
  end

endmodule

// File: rtl/man_line_seq.sv
module man_line_seq
  import man_bus_pkg::*;
#(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  prim_t             prim,
  input  logic [LANE_W-1:0] din,
  output logic              busy,
  output logic              done,
  output logic              ill,
  output logic              cs_n,
  output logic              sck,
  output logic [LANE_W-1:0] dout,
  output logic [BYTE_W-1:0] rx
);

  localparam int unsigned TMR_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [TMR_W-1:0] HALF_M1 = TMR_W'(SCK_HALF - 1);

  seq_st_e            st_q, st_d;
  logic [TMR_W-1:0]   tmr_q, tmr_d;
  logic [PULSE_W-1:0] cnt_q, cnt_d;
  logic               cs_q, cs_d;
  logic               sck_q, sck_d;
  logic [LANE_W-1:0]  dout_q, dout_d;
  logic [BYTE_W-1:0]  tx_q, tx_d;
  logic [BYTE_W-1:0]  rx_q, rx_d;
  logic [1:0]         lane_q, lane_d;
  logic               wr_q, wr_d;
  logic               sh_q, sh_d;
  logic               done_q, done_d;
  logic               ill_q, ill_d;
  logic [BYTE_W-1:0]  tx_nxt;
  logic               tmr_zero;

  assign tx_nxt   = tx_advance(tx_q, lane_q);
  assign tmr_zero = (tmr_q == '0);

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    cnt_d  = cnt_q;
    cs_d   = cs_q;
    sck_d  = sck_q;
    dout_d = dout_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    lane_d = lane_q;
    wr_d   = wr_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    ill_d  = ill_q;
    unique case (st_q)
      S_IDLE: begin
        if (issue) begin
          if (!prim.legal) begin
            ill_d = 1'b1;
          end else begin
            tmr_d = HALF_M1;
            unique case (prim.kind)
              K_CSHI: begin
                cs_d = 1'b1;
                st_d = S_CSW;
              end
              K_CSLO: begin
                cs_d = 1'b0;
                st_d = S_CSW;
              end
              K_CLK: begin
                st_d  = S_LOW;
                cnt_d = '0;
                sh_d  = 1'b0;
              end
              K_SHIFT: begin
                st_d   = S_LOW;
                cnt_d  = prim.last_pulse;
                lane_d = prim.lane_log;
                wr_d   = prim.wr;
                sh_d   = 1'b1;
                tx_d   = prim.data;
                dout_d = prim.wr ? lane_sym(prim.data, prim.lane_log) : '0;
              end
              default: st_d = S_IDLE;
            endcase
          end
        end
      end
      S_CSW: begin
        if (tmr_zero) begin
          st_d   = S_IDLE;
          done_d = 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      S_LOW: begin
        if (tmr_zero) begin
          st_d  = S_HIGH;
          sck_d = 1'b1;
          tmr_d = HALF_M1;
          if (sh_q && !wr_q) rx_d = rx_advance(rx_q, din, lane_q);
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      S_HIGH: begin
        if (tmr_zero) begin
          sck_d = 1'b0;
          if (cnt_q == '0) begin
            st_d   = S_IDLE;
            done_d = 1'b1;
            if (sh_q) dout_d = '0;
          end else begin
            cnt_d = cnt_q - 1'b1;
            st_d  = S_LOW;
            tmr_d = HALF_M1;
            if (sh_q) begin
              tx_d   = tx_nxt;
              dout_d = wr_q ? lane_sym(tx_nxt, lane_q) : '0;
            end
          end
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tmr_q  <= '0;
      cnt_q  <= '0;
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
      dout_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      lane_q <= 2'd0;
      wr_q   <= 1'b0;
      sh_q   <= 1'b0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      cnt_q  <= cnt_d;
      cs_q   <= cs_d;
      sck_q  <= sck_d;
      dout_q <= dout_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      lane_q <= lane_d;
      wr_q   <= wr_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      ill_q  <= ill_d;
    end
  end

  assign busy = (st_q != S_IDLE);
  assign done = done_q;
  assign ill  = ill_q;
  assign cs_n = cs_q;
  assign sck  = sck_q;
  assign dout = dout_q;
  assign rx   = rx_q;

endmodule

// File: rtl/man_bus_engine.sv
module man_bus_engine
  import man_bus_pkg::*;
#(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              man_en,
  input  logic              mux_sel,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              path_cs_n,
  input  logic              path_sck,
  input  logic [LANE_W-1:0] path_dout,
  input  logic [LANE_W-1:0] bus_din,
  output logic              bus_cs_n,
  output logic              bus_sck,
  output logic [LANE_W-1:0] bus_dout,
  output logic [BYTE_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              link_idle,
  output logic              ill_op,
  output logic              cmd_overrun
);

  logic              routed;
  logic              cmd_in;
  logic              issue;
  logic [CMD_W-1:0]  issue_word;
  logic              hold_full;
  logic              seq_busy;
  prim_t             prim;
  logic              eng_cs_n;
  logic              eng_sck;
  logic [LANE_W-1:0] eng_dout;

  assign routed = mux_sel && man_en;
  assign cmd_in = cmd_valid && routed;

  man_cmd_hold i_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_in     (cmd_in),
    .cmd_word   (cmd_word),
    .ready      (!seq_busy),
    .issue      (issue),
    .issue_word (issue_word),
    .hold_full  (hold_full),
    .overrun    (cmd_overrun)
  );

  man_cmd_decode i_dec (
    .word (issue_word),
    .prim (prim)
  );

  man_line_seq #(.SCK_HALF(SCK_HALF)) i_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .issue (issue),
    .prim  (prim),
    .din   (bus_din),
    .busy  (seq_busy),
    .done  (done),
    .ill   (ill_op),
    .cs_n  (eng_cs_n),
    .sck   (eng_sck),
    .dout  (eng_dout),
    .rx    (rd_data)
  );

  always_comb begin
    if (!mux_sel) begin
      bus_cs_n = path_cs_n;
      bus_sck  = path_sck;
      bus_dout = path_dout;
    end else if (man_en) begin
      bus_cs_n = eng_cs_n;
      bus_sck  = eng_sck;
      bus_dout = eng_dout;
    end else begin
      bus_cs_n = 1'b1;
      bus_sck  = 1'b0;
      bus_dout = '0;
    end
  end

  assign busy      = seq_busy;
  assign link_idle = !seq_busy && !hold_full;

endmodule

module man_bus_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       man_en,
  input logic       mux_sel,
  input logic       bus_sck,
  input logic [3:0] bus_dout,
  input logic       busy,
  input logic       done,
  input logic       link_idle,
  input logic       ill_op,
  input logic       cmd_overrun
);

  // R6: the serial clock is high only inside a running primitive
  p_sck_needs_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel && man_en && bus_sck) |-> busy);

  // R6: done follows the last busy cycle
  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy || $past(busy)) && $past(busy));

  // R4: lanes do not move while the clock is high
  p_dout_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel && man_en && bus_sck && $past(bus_sck) && $past(mux_sel && man_en))
      |-> $stable(bus_dout));

  // R7: idle excludes busy
  p_idle_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    link_idle |-> !busy);

  // R7: overrun flag is sticky
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_overrun |=> cmd_overrun);

  // R8: illegal flag is sticky
  p_ill_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ill_op |=> ill_op);

endmodule

bind man_bus_engine man_bus_engine_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .man_en      (man_en),
  .mux_sel     (mux_sel),
  .bus_sck     (bus_sck),
  .bus_dout    (bus_dout),
  .busy        (busy),
  .done        (done),
  .link_idle   (link_idle),
  .ill_op      (ill_op),
  .cmd_overrun (cmd_overrun)
);

// File: tb/test_man_bus_engine.sv
module test_man_bus_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        man_en, mux_sel, cmd_valid;
  logic [13:0] cmd_word;
  logic        path_cs_n, path_sck;
  logic [3:0]  path_dout;
  logic [3:0]  bus_din;
  logic        bus_cs_n, bus_sck;
  logic [3:0]  bus_dout;
  logic [7:0]  rd_data;
  logic        busy, done, link_idle, ill_op, cmd_overrun;

  always #10 clk = ~clk;

  man_bus_engine i_man_bus_engine (
    .clk(clk), .rst_n(rst_n), .man_en(man_en), .mux_sel(mux_sel),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .path_cs_n(path_cs_n), .path_sck(path_sck), .path_dout(path_dout),
    .bus_din(bus_din), .bus_cs_n(bus_cs_n), .bus_sck(bus_sck),
    .bus_dout(bus_dout), .rd_data(rd_data), .busy(busy), .done(done),
    .link_idle(link_idle), .ill_op(ill_op), .cmd_overrun(cmd_overrun)
  );

  int checks = 0;
  int fails  = 0;
  int pcnt = 0;
  int bcnt = 0;
  int dcnt = 0;
  logic sck_prev = 1'b0;
  logic [3:0] syms [0:63];

  logic [7:0] rx_pat = 8'h00;
  int rx_ll = 0;
  int rx_base = 0;

  function automatic logic [3:0] rx_sym(logic [7:0] p, int ll, int k);
    int lanes = 1 << ll;
    int amt = k * lanes;
    logic [7:0] s;
    s = (amt >= 8) ? 8'h00 : (p << amt);
    case (ll)
      0:       rx_sym = {3'b000, s[7]};
      1:       rx_sym = {2'b00, s[7:6]};
      default: rx_sym = s[7:4];
    endcase
  endfunction

  assign bus_din = rx_sym(rx_pat, rx_ll, pcnt - rx_base);

  always @(negedge clk) begin
    if (mux_sel && man_en && bus_sck && !sck_prev) begin
      syms[pcnt % 64] = bus_dout;
      pcnt = pcnt + 1;
    end
    sck_prev = bus_sck;
    if (busy) bcnt = bcnt + 1;
    if (done) dcnt = dcnt + 1;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic send(logic [13:0] w);
    cmd_valid = 1'b1;
    cmd_word  = w;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!link_idle && n < 2000) begin
      tick();
      n++;
    end
  endtask

  function automatic int rebuild(int p0, int n, int ll);
    int v = 0;
    int lanes = 1 << ll;
    int mask = (1 << lanes) - 1;
    for (int k = 0; k < n; k++) v = (v << lanes) | (int'(syms[(p0 + k) % 64]) & mask);
    return v & 8'hFF;
  endfunction

  function automatic int upper_bits(int p0, int n, int ll);
    int acc = 0;
    int lanes = 1 << ll;
    int mask = (1 << lanes) - 1;
    for (int k = 0; k < n; k++) acc = acc | (int'(syms[(p0 + k) % 64]) & ~mask & 4'hF);
    return acc;
  endfunction

  task automatic t_reset();
    chk("R1", "cs_n", bus_cs_n, 1);
    chk("R1", "sck", bus_sck, 0);
    chk("R1", "dout", bus_dout, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "link_idle", link_idle, 1);
    chk("R1", "ill_op", ill_op, 0);
    chk("R1", "overrun", cmd_overrun, 0);
  endtask

  task automatic t_cs();
    int p0 = pcnt; int b0 = bcnt;
    send(14'h2100); wait_idle();
    chk("R2", "cs low level", bus_cs_n, 0);
    chk("R2", "cs low busy cycles", bcnt - b0, 2);
    chk("R2", "cs low pulses", pcnt - p0, 0);
    p0 = pcnt; b0 = bcnt;
    send(14'h2000); wait_idle();
    chk("R2", "cs high level", bus_cs_n, 1);
    chk("R2", "cs high busy cycles", bcnt - b0, 2);
    chk("R2", "cs high pulses", pcnt - p0, 0);
  endtask

  task automatic t_clk();
    int p0; int b0;
    send(14'h2100); wait_idle();
    p0 = pcnt; b0 = bcnt;
    send(14'h0200); wait_idle();
    chk("R3", "pulse count", pcnt - p0, 1);
    chk("R3", "busy cycles", bcnt - b0, 4);
    chk("R3", "cs unchanged", bus_cs_n, 0);
    chk("R3", "dout unchanged", bus_dout, 0);
    chk("R3", "dout during pulse", int'(syms[p0 % 64]), 0);
    send(14'h2000); wait_idle();
  endtask

  task automatic t_shift(logic [13:0] w, int ll, int npulse);
    int p0 = pcnt; int b0 = bcnt; int d0 = dcnt;
    send(w); wait_idle();
    chk("R4", "pulse count", pcnt - p0, npulse);
    chk("R4", "byte on lanes", rebuild(p0, npulse, ll), int'(w[7:0]));
    chk("R4", "unused lanes", upper_bits(p0, npulse, ll), 0);
    chk("R4", "dout after end", bus_dout, 0);
    chk("R6", "busy cycles", bcnt - b0, 4 * npulse);
    chk("R6", "done pulses", dcnt - d0, 1);
  endtask

  task automatic t_read(logic [13:0] w, int ll, int npulse, logic [7:0] pat);
    int p0 = pcnt;
    rx_pat = pat; rx_ll = ll; rx_base = pcnt;
    tick();
    send(w); wait_idle();
    chk("R5", "pulse count", pcnt - p0, npulse);
    chk("R5", "lanes held low", upper_bits(p0, npulse, 0) | rebuild(p0, npulse, 2), 0);
    chk("R5", "rd_data", rd_data, int'(pat));
  endtask

  task automatic t_hold();
    int p0 = pcnt; int b0 = bcnt; int d0 = dcnt;
    chk("R7", "overrun before", cmd_overrun, 0);
    cmd_valid = 1'b1; cmd_word = 14'h2881; tick();
    cmd_word = 14'h2942; tick();
    cmd_word = 14'h2AFF; tick();
    cmd_valid = 1'b0;
    chk("R7", "idle while held", link_idle, 0);
    wait_idle();
    chk("R7", "pulses of two commands", pcnt - p0, 12);
    chk("R7", "first byte", rebuild(p0, 8, 0), 8'h81);
    chk("R7", "held byte", rebuild(p0 + 8, 4, 1), 8'h42);
    chk("R7", "busy cycles", bcnt - b0, 48);
    chk("R7", "done pulses", dcnt - d0, 2);
    chk("R7", "overrun set", cmd_overrun, 1);
    tick(); tick();
    chk("R7", "overrun sticky", cmd_overrun, 1);
  endtask

  task automatic t_illegal();
    int p0 = pcnt; int b0 = bcnt;
    chk("R8", "flag before", ill_op, 0);
    send(14'h2F12); tick(); tick();
    chk("R8", "flag set", ill_op, 1);
    chk("R8", "no pulses", pcnt - p0, 0);
    chk("R8", "no busy", bcnt - b0, 0);
    chk("R8", "cs unchanged", bus_cs_n, 1);
    send(14'h3100); tick(); tick();
    chk("R8", "reserved bit: cs unchanged", bus_cs_n, 1);
    chk("R8", "reserved bit: no busy", bcnt - b0, 0);
    t_shift(14'h28C9, 0, 8);
    chk("R8", "flag sticky", ill_op, 1);
  endtask

  task automatic t_gate();
    int p0 = pcnt; int b0 = bcnt;
    man_en = 1'b0; tick();
    send(14'h28FF); tick(); tick();
    chk("R9", "no busy when disabled", bcnt - b0, 0);
    chk("R9", "idle when disabled", link_idle, 1);
    mux_sel = 1'b0; man_en = 1'b1; tick();
    send(14'h2100); tick(); tick();
    chk("R9", "no busy when unrouted", bcnt - b0, 0);
    mux_sel = 1'b1; tick();
    chk("R9", "cs not lowered", bus_cs_n, 1);
    send(14'h0200); wait_idle();
    chk("R9", "only own pulse", pcnt - p0, 1);
    chk("R9", "only own busy", bcnt - b0, 4);
  endtask

  task automatic t_mux();
    mux_sel = 1'b0; path_cs_n = 1'b0; path_sck = 1'b1; path_dout = 4'hA; tick();
    chk("R10", "path cs", bus_cs_n, 0);
    chk("R10", "path sck", bus_sck, 1);
    chk("R10", "path dout", bus_dout, 4'hA);
    mux_sel = 1'b1; man_en = 1'b0; tick();
    chk("R10", "parked cs", bus_cs_n, 1);
    chk("R10", "parked sck", bus_sck, 0);
    chk("R10", "parked dout", bus_dout, 0);
    man_en = 1'b1; path_cs_n = 1'b1; path_sck = 1'b0; path_dout = 4'h0; tick();
  endtask

  task automatic t_slave_reset();
    int p0 = pcnt;
    send(14'h2100); wait_idle();
    chk("R11", "cs low", bus_cs_n, 0);
    send(14'h2800); wait_idle();
    chk("R11", "cs still low", bus_cs_n, 0);
    send(14'h2000); wait_idle();
    chk("R11", "cs high", bus_cs_n, 1);
    for (int i = 0; i < 4; i++) begin
      send(14'h2800); wait_idle();
    end
    chk("R11", "total pulses", pcnt - p0, 40);
    chk("R11", "link idle", link_idle, 1);
    chk("R11", "cs high at end", bus_cs_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; man_en = 1'b1; mux_sel = 1'b1; cmd_valid = 1'b0; cmd_word = '0;
    path_cs_n = 1'b1; path_sck = 1'b0; path_dout = 4'h0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_cs();
    t_clk();
    t_shift(14'h28A5, 0, 8);
    t_shift(14'h293C, 1, 4);
    t_shift(14'h2A96, 2, 2);
    t_read(14'h08FF, 0, 8, 8'hC3);
    t_read(14'h0900, 1, 4, 8'h5A);
    t_read(14'h0A00, 2, 2, 8'h7E);
    t_illegal();
    t_hold();
    t_gate();
    t_mux();
    t_slave_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule